// File: doc/BRIEF.md
# System Configuration Register Bank

A small bank of configuration words on a simple single-cycle register bus. Software uses it to choose which memory answers at address zero after boot, to move peripheral DMA requests between channels, to strengthen the drive of individual I2C-capable pins, to pick the envelope source of an infrared modulator, to assign a GPIO port to each external-interrupt line, and to connect fault sources to the break input of a motor-control timer.

The decoded selections leave the block as plain wires. The DMA routing is computed inside: each peripheral request enters on its own bit and is steered to its default or alternate channel. The break output combines the live fault events with the enables that software has connected.

There are two reset domains. The bus reset clears the ordinary configuration. The system reset also reloads the boot selection from a strap input and clears the break connections. Once a break connection is set, only a system reset clears it.

Top module: `sys_cfg_bank`

## Requirements
- R1: While `sys_rst_ni` is low, the boot selection loads `boot_strap_i` on each clock edge. The bus reset (`rst_ni` low) and all bus traffic other than a write to word 0 leave the boot selection unchanged.
- R2: The boot selection codes are 00 for main flash, 01 for system flash and 11 for SRAM. A write of code 10 to word 0 bits [1:0] leaves the boot selection unchanged.
- R3: Word 0 reads back the boot selection in [1:0], the DMA remap enables in [12:8], the pin drive enables in [23:16] and the IR envelope select in [27:26]. All other bits of word 0 read as zero and ignore writes.
- R4: Interrupt line n is held in word 1+(n>>2) at bits [4*(n&3)+3 : 4*(n&3)], and it is driven on `exti_port_o[4n+3:4n]`. Port codes 0 to 5 select ports A to F.
- R5: Port code 5 is accepted only for lines 0 to 10. A field written with code 5 for lines 11 to 15, or with any code from 6 to 15, keeps its previous value.
- R6: With a remap enable clear, each request goes to its default channel. Source bits 0 to 4 go to channel bits 0, 2, 2, 1 and 0. Channel bit k is channel k+1.
- R7: With a remap enable set (word 0 bit 8+s for source s), source s goes to its alternate channel bit instead. The alternates are 1, 3, 4, 3 and 1.
- R8: Each channel output is the OR of all requests currently routed to that channel.
- R9: Word 5 bits [2:0] connect the supply-monitor (bit 0), SRAM-parity (bit 1) and lockup (bit 2) events. Writing a 1 sets a bit. Writing a 0 never clears one, and bits above [2:0] read as zero.
- R10: `brk_o` is high exactly when some connected bit of word 5 has its `brk_evt_i` bit high.
- R11: The bus reset clears the remap, drive, IR and line-select fields. It keeps the boot selection and word 5.
- R12: The system reset clears every field, including word 5, and reloads the boot selection as in R1.
- R13: The IR select codes are 00 for the timer, 01 for UART A and 10 for UART B. Code 11 is ignored. `fmp_en_o` and `ir_env_sel_o` follow the stored fields.
- R14: Words 6 and 7 read as zero, and writes to them change no other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Bus reset, active low, asynchronous |
| sys_rst_ni | input | 1 | System reset, active low |
| boot_strap_i | input | 2 | Boot selection strap, loaded during system reset |
| sel_i | input | 1 | Bus access select |
| wr_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W (3) | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| boot_map_o | output | 2 | Boot memory selection |
| fmp_en_o | output | FMP_N (8) | Per-pin fast-mode-plus drive enables |
| ir_env_sel_o | output | 2 | IR envelope source select |
| exti_port_o | output | 4*N_LINES (64) | Port code per interrupt line |
| dma_src_req_i | input | 5 | Requests: timer A, timer B, UART rx, UART tx, ADC |
| dma_ch_req_o | output | 5 | Requests per channel, bit k is channel k+1 |
| brk_evt_i | input | 3 | Live events: supply monitor, SRAM parity, lockup |
| brk_o | output | 1 | Timer break request |

## Verification
The bench builds the block with its default parameters: four select words of four 4-bit fields, eight drive enables and a 3-bit word address. With these values the port-F cutoff at line 10 falls inside word 3, so a single write shows the same code accepted for some fields and refused for another. The 3-bit address leaves words 6 and 7 unmapped, so writes to addresses that decode to nothing can be tried. The five DMA sources are driven alone and together, with remap masks of none, all and one, so that both channel sharing and channel moves are observed.

// File: rtl/sys_cfg_pkg.sv
package sys_cfg_pkg;
  localparam int unsigned DMA_SRC_N = 5;
  localparam int unsigned DMA_CH_N  = 5;
  localparam int unsigned BRK_SRC_N = 3;

  typedef enum logic [1:0] {
    BOOT_MAIN = 2'b00,
    BOOT_SYS  = 2'b01,
    BOOT_RSVD = 2'b10,
    BOOT_SRAM = 2'b11
  } boot_map_e;

  typedef enum logic [1:0] {
    IR_TIMER  = 2'b00,
    IR_UART_A = 2'b01,
    IR_UART_B = 2'b10,
    IR_RSVD   = 2'b11
  } ir_env_e;

  // channel index (0 = channel 1) per source: tim_a, tim_b, uart_rx, uart_tx, adc
  localparam int unsigned DMA_DEF_CH [DMA_SRC_N] = '{0, 2, 2, 1, 0};
  localparam int unsigned DMA_ALT_CH [DMA_SRC_N] = '{1, 3, 4, 3, 1};

  localparam int unsigned REG_CFG   = 0;
  localparam int unsigned REG_LINE0 = 1;

  localparam int unsigned BOOT_LSB  = 0;
  localparam int unsigned REMAP_LSB = 8;
  localparam int unsigned FMP_LSB   = 16;
  localparam int unsigned IR_LSB    = 26;
endpackage

// File: rtl/sys_cfg_regs.sv
module sys_cfg_regs
  import sys_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W           = 3,
  parameter int unsigned FMP_N            = 8,
  parameter int unsigned N_LINE_REGS      = 4,
  parameter int unsigned FIELDS_PER_REG   = 4,
  parameter int unsigned FIELD_W          = 4,
  parameter int unsigned N_PORTS          = 6,
  parameter int unsigned PORT_F_LAST_LINE = 10,
  localparam int unsigned N_LINES         = N_LINE_REGS * FIELDS_PER_REG
) (
  input  logic                         clk_i,
  input  logic                         bus_rst_ni,
  input  logic                         sys_rst_ni,
  input  logic [1:0]                   boot_strap_i,
  input  logic                         sel_i,
  input  logic                         wr_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [31:0]                  wdata_i,
  input  logic [BRK_SRC_N-1:0]         brk_en_i,
  output logic [31:0]                  rdata_o,
  output logic                         brk_wr_o,
  output boot_map_e                    boot_map_o,
  output logic [DMA_SRC_N-1:0]         remap_o,
  output logic [FMP_N-1:0]             fmp_o,
  output ir_env_e                      ir_o,
  output logic [N_LINES*FIELD_W-1:0]   line_port_o
);
  localparam int unsigned BRK_IDX = REG_LINE0 + N_LINE_REGS;

  logic wr_en, cfg_wr;
  boot_map_e boot_q;
  ir_env_e ir_q;
  logic [DMA_SRC_N-1:0] remap_q;
  logic [FMP_N-1:0] fmp_q;
  logic [FIELD_W-1:0] line_q [N_LINES];
  logic [1:0] boot_w, ir_w;

  assign wr_en    = sel_i & wr_i;
  assign cfg_wr   = wr_en && (addr_i == ADDR_W'(REG_CFG));
  assign brk_wr_o = wr_en && (addr_i == ADDR_W'(BRK_IDX));
  assign boot_w   = wdata_i[BOOT_LSB +: 2];
  assign ir_w     = wdata_i[IR_LSB +: 2];

  // boot field: synchronous strap load, untouched by bus reset
  always_ff @(posedge clk_i) begin
    if (!sys_rst_ni)                        boot_q <= boot_map_e'(boot_strap_i);
    else if (cfg_wr && boot_w != BOOT_RSVD) boot_q <= boot_map_e'(boot_w);
  end

  always_ff @(posedge clk_i or negedge bus_rst_ni) begin
    if (!bus_rst_ni) begin
      remap_q <= '0;
      fmp_q   <= '0;
      ir_q    <= IR_TIMER;
    end else if (cfg_wr) begin
      remap_q <= wdata_i[REMAP_LSB +: DMA_SRC_N];
      fmp_q   <= wdata_i[FMP_LSB +: FMP_N];
      if (ir_w != IR_RSVD) ir_q <= ir_env_e'(ir_w);
    end
  end

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    localparam int unsigned RIDX     = l / FIELDS_PER_REG;
    localparam int unsigned FIDX     = l % FIELDS_PER_REG;
    localparam int unsigned MAX_CODE = (l <= PORT_F_LAST_LINE) ? N_PORTS - 1 : N_PORTS - 2;
    logic [FIELD_W-1:0] cand;
    logic hit;
    assign cand = wdata_i[FIDX*FIELD_W +: FIELD_W];
    assign hit  = wr_en && (addr_i == ADDR_W'(REG_LINE0 + RIDX)) && (32'(cand) <= MAX_CODE);
    always_ff @(posedge clk_i or negedge bus_rst_ni) begin
      if (!bus_rst_ni) line_q[l] <= '0;
      else if (hit)    line_q[l] <= cand;
    end
    assign line_port_o[l*FIELD_W +: FIELD_W] = line_q[l];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(REG_CFG)) begin
      rdata_o[BOOT_LSB +: 2]          = boot_q;
      rdata_o[REMAP_LSB +: DMA_SRC_N] = remap_q;
      rdata_o[FMP_LSB +: FMP_N]       = fmp_q;
      rdata_o[IR_LSB +: 2]            = ir_q;
    end
    if (addr_i == ADDR_W'(BRK_IDX)) rdata_o[BRK_SRC_N-1:0] = brk_en_i;
    for (int r = 0; r < N_LINE_REGS; r++) begin
      if (addr_i == ADDR_W'(REG_LINE0 + r)) begin
        for (int f = 0; f < FIELDS_PER_REG; f++)
          rdata_o[f*FIELD_W +: FIELD_W] = line_q[r*FIELDS_PER_REG + f];
      end
    end
  end

  assign boot_map_o = boot_q;
  assign remap_o    = remap_q;
  assign fmp_o      = fmp_q;
  assign ir_o       = ir_q;
endmodule

// File: rtl/sys_cfg_dma_route.sv
module sys_cfg_dma_route
  import sys_cfg_pkg::*;
(
  input  logic [DMA_SRC_N-1:0] remap_i,
  input  logic [DMA_SRC_N-1:0] req_i,
  output logic [DMA_CH_N-1:0]  ch_o
);
  always_comb begin
    ch_o = '0;
    for (int s = 0; s < DMA_SRC_N; s++) begin
      if (req_i[s]) begin
        if (remap_i[s]) ch_o = ch_o | (DMA_CH_N'(1) << DMA_ALT_CH[s]);
        else            ch_o = ch_o | (DMA_CH_N'(1) << DMA_DEF_CH[s]);
      end
    end
  end
endmodule

// File: rtl/sys_cfg_brk.sv
module sys_cfg_brk
  import sys_cfg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 sys_rst_ni,
  input  logic                 wr_i,
  input  logic [BRK_SRC_N-1:0] set_i,
  input  logic [BRK_SRC_N-1:0] evt_i,
  output logic [BRK_SRC_N-1:0] en_o,
  output logic                 brk_o
);
  logic [BRK_SRC_N-1:0] en_q;

  // set-only until system reset
  always_ff @(posedge clk_i or negedge sys_rst_ni) begin
    if (!sys_rst_ni) en_q <= '0;
    else if (wr_i)   en_q <= en_q | set_i;
  end

  assign en_o  = en_q;
  assign brk_o = |(en_q & evt_i);
endmodule

// File: rtl/sys_cfg_bank.sv
module sys_cfg_bank
  import sys_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W           = 3,
  parameter int unsigned FMP_N            = 8,
  parameter int unsigned N_LINE_REGS      = 4,
  parameter int unsigned FIELDS_PER_REG   = 4,
  parameter int unsigned FIELD_W          = 4,
  parameter int unsigned N_PORTS          = 6,
  parameter int unsigned PORT_F_LAST_LINE = 10,
  localparam int unsigned N_LINES         = N_LINE_REGS * FIELDS_PER_REG
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sys_rst_ni,
  input  logic [1:0]                 boot_strap_i,
  input  logic                       sel_i,
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [31:0]                wdata_i,
  output logic [31:0]                rdata_o,
  output logic [1:0]                 boot_map_o,
  output logic [FMP_N-1:0]           fmp_en_o,
  output logic [1:0]                 ir_env_sel_o,
  output logic [N_LINES*FIELD_W-1:0] exti_port_o,
  input  logic [DMA_SRC_N-1:0]       dma_src_req_i,
  output logic [DMA_CH_N-1:0]        dma_ch_req_o,
  input  logic [BRK_SRC_N-1:0]       brk_evt_i,
  output logic                       brk_o
);
  logic bus_rst_n;
  logic brk_wr;
  logic [BRK_SRC_N-1:0] brk_en;
  logic [DMA_SRC_N-1:0] remap;
  boot_map_e boot_map;
  ir_env_e ir_sel;

  // system reset implies bus reset
  assign bus_rst_n = rst_ni & sys_rst_ni;

  sys_cfg_regs #(
    .ADDR_W(ADDR_W), .FMP_N(FMP_N), .N_LINE_REGS(N_LINE_REGS),
    .FIELDS_PER_REG(FIELDS_PER_REG), .FIELD_W(FIELD_W),
    .N_PORTS(N_PORTS), .PORT_F_LAST_LINE(PORT_F_LAST_LINE)
  ) u_regs (
    .clk_i(clk_i), .bus_rst_ni(bus_rst_n), .sys_rst_ni(sys_rst_ni),
    .boot_strap_i(boot_strap_i), .sel_i(sel_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .brk_en_i(brk_en),
    .rdata_o(rdata_o), .brk_wr_o(brk_wr), .boot_map_o(boot_map),
    .remap_o(remap), .fmp_o(fmp_en_o), .ir_o(ir_sel),
    .line_port_o(exti_port_o)
  );

  sys_cfg_dma_route u_route (
    .remap_i(remap), .req_i(dma_src_req_i), .ch_o(dma_ch_req_o)
  );

  sys_cfg_brk u_brk (
    .clk_i(clk_i), .sys_rst_ni(sys_rst_ni), .wr_i(brk_wr),
    .set_i(wdata_i[BRK_SRC_N-1:0]), .evt_i(brk_evt_i),
    .en_o(brk_en), .brk_o(brk_o)
  );

  assign boot_map_o   = boot_map;
  assign ir_env_sel_o = ir_sel;
endmodule

// File: rtl/sys_cfg_bank_chk.sv
module sys_cfg_bank_chk
  import sys_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W           = 3,
  parameter int unsigned N_LINES          = 16,
  parameter int unsigned N_LINE_REGS      = 4,
  parameter int unsigned FIELD_W          = 4,
  parameter int unsigned N_PORTS          = 6,
  parameter int unsigned PORT_F_LAST_LINE = 10
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       sys_rst_ni,
  input logic                       sel_i,
  input logic                       wr_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [31:0]                rdata_o,
  input logic [1:0]                 boot_map_o,
  input logic [N_LINES*FIELD_W-1:0] exti_port_o,
  input logic [DMA_SRC_N-1:0]       dma_src_req_i,
  input logic [DMA_CH_N-1:0]        dma_ch_req_o,
  input logic [DMA_SRC_N-1:0]       remap_i,
  input logic [BRK_SRC_N-1:0]       brk_en_i,
  input logic [BRK_SRC_N-1:0]       brk_evt_i,
  input logic                       brk_o
);
  localparam int unsigned FIRST_FREE = REG_LINE0 + N_LINE_REGS + 1;

  p_boot_hold_r1: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
    !(sel_i && wr_i && addr_i == ADDR_W'(REG_CFG)) |=> $stable(boot_map_o));

  p_boot_no_rsvd_r2: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
    boot_map_o != 2'b10);

  for (genvar l = 0; l < N_LINES; l++) begin : g_line_chk
    localparam int unsigned MAXC = (l <= PORT_F_LAST_LINE) ? N_PORTS - 1 : N_PORTS - 2;
    p_line_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !sys_rst_ni)
      32'(exti_port_o[l*FIELD_W +: FIELD_W]) <= MAXC);
  end

  p_dma_default_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !sys_rst_ni)
    dma_src_req_i[0] && !remap_i[0] |-> dma_ch_req_o[0]);

  p_dma_alt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !sys_rst_ni)
    dma_src_req_i[2] && remap_i[2] |-> dma_ch_req_o[4]);

  p_brk_sticky_r9: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
    brk_en_i != '0 |=> ((brk_en_i & $past(brk_en_i)) == $past(brk_en_i)));

  p_brk_lockup_r10: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
    brk_en_i[2] && brk_evt_i[2] |-> brk_o);

  p_brk_quiet_r10: assert property (@(posedge clk_i) disable iff (!sys_rst_ni)
    brk_evt_i == '0 |-> !brk_o);

  p_unmapped_r14: assert property (@(posedge clk_i) disable iff (!rst_ni || !sys_rst_ni)
    sel_i && 32'(addr_i) >= FIRST_FREE |-> rdata_o == '0);
endmodule

bind sys_cfg_bank sys_cfg_bank_chk #(
  .ADDR_W(ADDR_W), .N_LINES(N_LINES), .N_LINE_REGS(N_LINE_REGS),
  .FIELD_W(FIELD_W), .N_PORTS(N_PORTS), .PORT_F_LAST_LINE(PORT_F_LAST_LINE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sys_rst_ni(sys_rst_ni),
  .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i), .rdata_o(rdata_o),
  .boot_map_o(boot_map_o), .exti_port_o(exti_port_o),
  .dma_src_req_i(dma_src_req_i), .dma_ch_req_o(dma_ch_req_o),
  .remap_i(remap), .brk_en_i(brk_en), .brk_evt_i(brk_evt_i), .brk_o(brk_o)
);

// File: tb/sys_cfg_bank_bench.sv
`timescale 1ns/1ps
module sys_cfg_bank_bench;
  localparam int K_RD = 0, K_BOOT = 1, K_DMA = 2, K_BRK = 3, K_LINE = 4, K_FMP = 5, K_IR = 6;

  typedef struct {
    int          kind;
    int          idx;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk = 0;
  logic        rst_ni = 0, sys_rst_ni = 0;
  logic [1:0]  boot_strap = 2'b01;
  logic        sel = 0, wr = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  boot_map, ir_sel;
  logic [7:0]  fmp;
  logic [63:0] exti;
  logic [4:0]  dma_req = '0, dma_ch;
  logic [2:0]  brk_evt = '0;
  logic        brk;

  int checks = 0, errors = 0;
  bit done = 0;
  item_t q[$];
  event chk_ev;

  always #10 clk = ~clk;

  sys_cfg_bank u_sys_cfg_bank (
    .clk_i(clk), .rst_ni(rst_ni), .sys_rst_ni(sys_rst_ni),
    .boot_strap_i(boot_strap), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .boot_map_o(boot_map),
    .fmp_en_o(fmp), .ir_env_sel_o(ir_sel), .exti_port_o(exti),
    .dma_src_req_i(dma_req), .dma_ch_req_o(dma_ch),
    .brk_evt_i(brk_evt), .brk_o(brk)
  );

  function automatic logic [31:0] observe(int kind, int idx);
    case (kind)
      K_RD:    return rdata;
      K_BOOT:  return 32'(boot_map);
      K_DMA:   return 32'(dma_ch);
      K_BRK:   return 32'(brk);
      K_LINE:  return 32'(exti[idx*4 +: 4]);
      K_FMP:   return 32'(fmp);
      default: return 32'(ir_sel);
    endcase
  endfunction

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(chk_ev);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = observe(it.kind, it.idx);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h", it.req, it.kind, it.idx, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(int kind, int idx, logic [31:0] exp, string req);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
    q.push_back(it);
    -> chk_ev;
    #3;
  endtask

  task automatic bus_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0; wdata = '0;
  endtask

  task automatic read_check(logic [2:0] a, logic [31:0] exp, string req);
    sel = 1; wr = 0; addr = a;
    expect_val(K_RD, 0, exp, req);
    sel = 0;
  endtask

  function automatic logic [4:0] route(logic [4:0] req, logic [4:0] rm);
    int def_ch [5] = '{0, 2, 2, 1, 0};
    int alt_ch [5] = '{1, 3, 4, 3, 1};
    logic [4:0] r = '0;
    for (int s = 0; s < 5; s++)
      if (req[s]) r[rm[s] ? alt_ch[s] : def_ch[s]] = 1'b1;
    return r;
  endfunction

  task automatic dma_check(logic [4:0] req, logic [4:0] rm, string tag);
    @(negedge clk);
    dma_req = req;
    expect_val(K_DMA, 0, 32'(route(req, rm)), tag);
    dma_req = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_ni = 1; sys_rst_ni = 1;
    @(negedge clk);
    expect_val(K_BOOT, 0, 32'h1, "R1 strap load");
    read_check(3'd0, 32'h1, "R3 cfg reset");
    read_check(3'd5, 32'h0, "R12 brk reset");
    read_check(3'd1, 32'h0, "R4 lines reset");

    bus_write(3'd0, 32'h08A5_1503);
    read_check(3'd0, 32'h08A5_1503, "R3 cfg readback");
    expect_val(K_BOOT, 0, 32'h3, "R2 sram boot");
    expect_val(K_FMP, 0, 32'hA5, "R13 fmp");
    expect_val(K_IR, 0, 32'h2, "R13 ir uart b");
    bus_write(3'd0, 32'h08A5_1502);
    read_check(3'd0, 32'h08A5_1503, "R2 rsvd boot ignored");
    bus_write(3'd0, 32'hFCA5_1503);
    read_check(3'd0, 32'h08A5_1503, "R13 rsvd ir ignored");
    bus_write(3'd0, 32'hF4FC_E0FF);
    read_check(3'd0, 32'h04FC_0003, "R3 reserved bits zero");

    for (int s = 0; s < 5; s++) dma_check(5'(1 << s), 5'h00, "R6 default route");
    dma_check(5'h1F, 5'h00, "R8 shared default");
    bus_write(3'd0, 32'h04FC_1F03);
    for (int s = 0; s < 5; s++) dma_check(5'(1 << s), 5'h1F, "R7 alt route");
    dma_check(5'h1F, 5'h1F, "R8 shared alt");
    dma_check(5'h0A, 5'h1F, "R8 two onto ch4");
    bus_write(3'd0, 32'h04FC_0403);
    dma_check(5'h04, 5'h04, "R7 uart rx alone");
    dma_check(5'h06, 5'h04, "R7 partial remap");

    bus_write(3'd1, 32'h0000_5432);
    read_check(3'd1, 32'h5432, "R4 line word");
    expect_val(K_LINE, 3, 32'h5, "R4 line3 port F");
    expect_val(K_LINE, 0, 32'h2, "R4 line0 port C");
    bus_write(3'd1, 32'h0000_7666);
    read_check(3'd1, 32'h5432, "R5 bad codes ignored");
    bus_write(3'd3, 32'h0000_5555);
    read_check(3'd3, 32'h0555, "R5 port F cutoff");
    expect_val(K_LINE, 10, 32'h5, "R5 line10 F ok");
    bus_write(3'd4, 32'h0000_4321);
    read_check(3'd4, 32'h4321, "R4 top word");
    expect_val(K_LINE, 15, 32'h4, "R4 line15");
    bus_write(3'd4, 32'h0000_5555);
    read_check(3'd4, 32'h4321, "R5 F on high lines");

    bus_write(3'd6, 32'hFFFF_FFFF);
    bus_write(3'd7, 32'hFFFF_FFFF);
    read_check(3'd6, 32'h0, "R14 word6 zero");
    read_check(3'd7, 32'h0, "R14 word7 zero");
    read_check(3'd0, 32'h04FC_0403, "R14 cfg untouched");
    read_check(3'd1, 32'h5432, "R14 lines untouched");

    bus_write(3'd5, 32'h5);
    read_check(3'd5, 32'h5, "R9 brk set");
    bus_write(3'd5, 32'h0);
    read_check(3'd5, 32'h5, "R9 brk sticky");
    bus_write(3'd5, 32'hFFFF_FFF8);
    read_check(3'd5, 32'h5, "R9 brk reserved");
    brk_evt = 3'b010; expect_val(K_BRK, 0, 32'h0, "R10 unconnected parity");
    brk_evt = 3'b100; expect_val(K_BRK, 0, 32'h1, "R10 lockup");
    brk_evt = 3'b001; expect_val(K_BRK, 0, 32'h1, "R10 supply monitor");
    brk_evt = 3'b000; expect_val(K_BRK, 0, 32'h0, "R10 idle");

    @(negedge clk); rst_ni = 0;
    repeat (2) @(negedge clk); rst_ni = 1;
    @(negedge clk);
    expect_val(K_BOOT, 0, 32'h3, "R1 boot kept on bus reset");
    read_check(3'd0, 32'h3, "R11 cfg cleared");
    read_check(3'd5, 32'h5, "R11 brk kept");
    read_check(3'd1, 32'h0, "R11 lines cleared");
    expect_val(K_LINE, 10, 32'h0, "R11 line10 cleared");
    dma_check(5'h1F, 5'h00, "R11 remap cleared");

    @(negedge clk); sys_rst_ni = 0; boot_strap = 2'b00;
    repeat (3) @(negedge clk); sys_rst_ni = 1;
    @(negedge clk);
    expect_val(K_BOOT, 0, 32'h0, "R12 strap reload");
    read_check(3'd5, 32'h0, "R12 brk cleared");
    brk_evt = 3'b111; expect_val(K_BRK, 0, 32'h0, "R12 no break");
    bus_write(3'd5, 32'h2);
    expect_val(K_BRK, 0, 32'h1, "R10 parity connected");
    brk_evt = 3'b000;

    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule